// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two 64-bit operands that are split into equal lanes: one lane of 64 bits, two of 32, four of 16 or eight of 8, selected by a lane-mode input. Every lane works alone. No carry or borrow crosses from one lane into the next, so one operation gives several independent narrow results in the same cycle.

A saturate control chooses between two kinds of result. Without it, each lane wraps modulo its own width. With it, a lane whose true result does not fit is clamped to that lane's limit, using either the signed or the unsigned range. A per-lane overflow flag reports which lanes went out of range, whether or not clamping was requested. Overflow never stops the block or raises an exception; a result is always produced. The datapath is combinational, with an optional output register that adds one cycle of latency.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode` sets the split: 0 gives one 64-bit lane, 1 gives two 32-bit lanes, 2 gives four 16-bit lanes and 3 gives eight 8-bit lanes. Lane i occupies result bits [i*w +: w], where w is the lane width.
- R2: A carry or borrow out of the top of a lane never changes any other lane.
- R3: With `sat_en` = 0, each lane returns its true sum or difference modulo 2^w.
- R4: With `sub_en` = 1, each lane computes op_a − op_b. This is done as op_a + ~op_b + 1, with the +1 injected at the bottom of every lane.
- R5: With `sat_en` = 1 and `signed_en` = 0, an add that overflows a lane returns all ones in that lane, and a subtract that underflows returns zero.
- R6: With `sat_en` = 1 and `signed_en` = 1, a lane that overflows positively returns 0 followed by ones (the most positive value), and a lane that overflows negatively returns 1 followed by zeros (the most negative value).
- R7: `lane_ovf_o[i]` is 1 exactly when lane i went out of range, for any value of `sat_en`. For unsigned operands this means a carry out on add or a borrow on subtract. For signed operands it means a two's-complement overflow. Bits at or above the lane count are 0.
- R8: The result and the flags are always produced, with no exception path. With OUT_REG = 1 they appear one clock after the operands, and reset drives both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First operand, all lanes packed |
| op_b | input | 64 | Second operand, all lanes packed |
| lane_mode | input | 2 | Lane split: 0 = 1x64, 1 = 2x32, 2 = 4x16, 3 = 8x8 |
| sub_en | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| sat_en | input | 1 | 1 = clamp out-of-range lanes, 0 = wrap |
| signed_en | input | 1 | 1 = lanes hold two's-complement values, 0 = unsigned |
| sum_o | output | 64 | Packed lane results |
| lane_ovf_o | output | 8 | Per-lane out-of-range flags, lane 0 in bit 0 |

## Verification
Some properties are checked by the bound checker on every cycle:
- the lowest lane segment wraps correctly when saturation is off;
- the full-width mode-0 result matches a plain 64-bit add or subtract;
- in byte mode, the second byte is unaffected by a carry out of the first;
- in byte mode, the clamp values for unsigned add, unsigned subtract and signed operands are correct;
- flag bits for lanes that do not exist stay zero.

Other behaviours can only be shown by the bench's scenarios, which compare every lane against an independent model. These are clamping and isolation in the wider 16-bit and 32-bit lanes, the flags of the upper lanes, the one-cycle latency and the reset values.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   // Operation controls shared by every lane of the datapath.
   typedef struct packed {
      logic sub;   // subtract op_b from op_a
      logic sat;   // clamp instead of wrap
      logic sgn;   // two's-complement lanes
   } simd_op_t;

   // Number of minimum-width segments in one lane for a given mode.
   function automatic int unsigned segs_per_lane(int unsigned num_seg, int unsigned mode);
      return num_seg >> mode;
   endfunction

endpackage

// File: rtl/simd_lane_map.sv
// Turns the lane-mode code into segment-level lane structure.
module simd_lane_map
   import simd_add_pkg::*;
#(
   parameter int NUM_SEG = 8,
   parameter int LOG_SEG = 3,
   parameter int MODE_W  = 2,
   parameter int SEG_IW  = 3
) (
   input  logic [MODE_W-1:0]  mode_i,
   output logic [SEG_IW-1:0]  mask_o,     // segments per lane minus one
   output logic [NUM_SEG-1:0] first_o,    // segment is the bottom of a lane
   output logic [NUM_SEG-1:0] lane_ok_o   // lane index exists in this mode
);

   int m_eff;
   int span;
   int lanes;

   always_comb begin
      m_eff = int'(mode_i);
      if (m_eff > LOG_SEG) m_eff = LOG_SEG;
      span   = int'(segs_per_lane(NUM_SEG, m_eff));
      lanes  = 1 << m_eff;
      mask_o = SEG_IW'(span - 1);
      for (int k = 0; k < NUM_SEG; k++) begin
         first_o[k]   = ((k & (span - 1)) == 0);
         lane_ok_o[k] = (k < lanes);
      end
   end

endmodule

// File: rtl/simd_seg_chain.sv
// Ripple of minimum-width segment adders.
// The carry into each segment is cut at lane bottoms.
module simd_seg_chain #(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 8,
   localparam int DATA_W = SEG_W * NUM_SEG
) (
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic               sub_i,
   input  logic [NUM_SEG-1:0] first_i,
   output logic [DATA_W-1:0]  sum_o,
   output logic [NUM_SEG-1:0] cout_o,
   output logic [NUM_SEG-1:0] sovf_o
);

   logic [NUM_SEG:0] cy;
   assign cy[0] = 1'b0;

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      logic [SEG_W-1:0] av;
      logic [SEG_W-1:0] bx;
      logic [SEG_W-1:0] sv;
      logic             cin;
      logic             co;

      assign av  = a_i[k*SEG_W +: SEG_W];
      assign bx  = b_i[k*SEG_W +: SEG_W] ^ {SEG_W{sub_i}};
      // lane bottom: inject the subtract +1; otherwise chain from below
      assign cin = first_i[k] ? sub_i : cy[k];
      assign {co, sv} = {1'b0, av} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};

      assign cy[k+1]   = co;
      assign cout_o[k] = co;
      assign sum_o[k*SEG_W +: SEG_W] = sv;
      assign sovf_o[k] = (av[SEG_W-1] == bx[SEG_W-1]) && (sv[SEG_W-1] != av[SEG_W-1]);
   end

endmodule

// File: rtl/simd_clamp.sv
// Per-lane range detection, clamping and overflow flag compaction.
module simd_clamp
   import simd_add_pkg::*;
#(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 8,
   parameter int SEG_IW  = 3,
   localparam int DATA_W = SEG_W * NUM_SEG
) (
   input  logic [DATA_W-1:0]  sum_i,
   input  logic [NUM_SEG-1:0] cout_i,
   input  logic [NUM_SEG-1:0] sovf_i,
   input  logic [NUM_SEG-1:0] a_sign_i,
   input  logic [NUM_SEG-1:0] lane_ok_i,
   input  logic [SEG_IW-1:0]  mask_i,
   input  simd_op_t           op_i,
   output logic [DATA_W-1:0]  res_o,
   output logic [NUM_SEG-1:0] ovf_o
);

   localparam logic [SEG_W-1:0] SEG_ONES = '1;
   localparam logic [SEG_W-1:0] SEG_ZERO = '0;
   localparam logic [SEG_W-1:0] SEG_SMAX = {1'b0, {(SEG_W-1){1'b1}}};
   localparam logic [SEG_W-1:0] SEG_SMIN = {1'b1, {(SEG_W-1){1'b0}}};

   // Out-of-range flag of every segment; only lane tops are meaningful.
   logic [NUM_SEG-1:0] seg_ovf;
   always_comb seg_ovf = op_i.sgn ? sovf_i : (cout_i ^ {NUM_SEG{op_i.sub}});

   int   top;
   logic is_top;

   always_comb begin
      res_o  = sum_i;
      top    = 0;
      is_top = 1'b0;
      for (int k = 0; k < NUM_SEG; k++) begin
         top    = k | int'(mask_i);
         is_top = (top == k);
         if (op_i.sat && seg_ovf[top]) begin
            if (op_i.sgn)
               res_o[k*SEG_W +: SEG_W] = a_sign_i[top] ? (is_top ? SEG_SMIN : SEG_ZERO)
                                                       : (is_top ? SEG_SMAX : SEG_ONES);
            else
               res_o[k*SEG_W +: SEG_W] = op_i.sub ? SEG_ZERO : SEG_ONES;
         end
      end
   end

   int span;
   int idx;

   always_comb begin
      span  = int'(mask_i) + 1;
      idx   = 0;
      ovf_o = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
         idx = (i + 1) * span - 1;
         if (lane_ok_i[i] && idx < NUM_SEG) ovf_o[i] = seg_ovf[idx];
      end
   end

endmodule

// File: rtl/simd_sat_adder.sv
// Partitioned add/subtract with per-lane wrap or saturation.
module simd_sat_adder
   import simd_add_pkg::*;
#(
   parameter int  DATA_W  = 64,
   parameter int  SEG_W   = 8,
   parameter bit  OUT_REG = 1'b1,
   localparam int NUM_SEG = DATA_W / SEG_W,
   localparam int LOG_SEG = $clog2(NUM_SEG),
   localparam int MODE_W  = $clog2(LOG_SEG + 1),
   localparam int SEG_IW  = LOG_SEG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  op_a,
   input  logic [DATA_W-1:0]  op_b,
   input  logic [MODE_W-1:0]  lane_mode,
   input  logic               sub_en,
   input  logic               sat_en,
   input  logic               signed_en,
   output logic [DATA_W-1:0]  sum_o,
   output logic [NUM_SEG-1:0] lane_ovf_o
);

   initial begin : p_param_chk
      if ((DATA_W % SEG_W) != 0 || NUM_SEG < 2 || (NUM_SEG & (NUM_SEG - 1)) != 0)
         $error("simd_sat_adder: DATA_W/SEG_W must be a power of two of at least 2");
   end

   simd_op_t           op;
   logic [SEG_IW-1:0]  seg_mask;
   logic [NUM_SEG-1:0] seg_first;
   logic [NUM_SEG-1:0] lane_ok;
   logic [DATA_W-1:0]  raw_sum;
   logic [NUM_SEG-1:0] seg_cout;
   logic [NUM_SEG-1:0] seg_sovf;
   logic [NUM_SEG-1:0] a_sign;
   logic [DATA_W-1:0]  res_c;
   logic [NUM_SEG-1:0] ovf_c;

   assign op = '{sub: sub_en, sat: sat_en, sgn: signed_en};

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_sign
      assign a_sign[k] = op_a[k*SEG_W + SEG_W - 1];
   end

   simd_lane_map #(
      .NUM_SEG (NUM_SEG),
      .LOG_SEG (LOG_SEG),
      .MODE_W  (MODE_W),
      .SEG_IW  (SEG_IW)
   ) u_map (
      .mode_i    (lane_mode),
      .mask_o    (seg_mask),
      .first_o   (seg_first),
      .lane_ok_o (lane_ok)
   );

   simd_seg_chain #(
      .SEG_W   (SEG_W),
      .NUM_SEG (NUM_SEG)
   ) u_chain (
      .a_i     (op_a),
      .b_i     (op_b),
      .sub_i   (sub_en),
      .first_i (seg_first),
      .sum_o   (raw_sum),
      .cout_o  (seg_cout),
      .sovf_o  (seg_sovf)
   );

   simd_clamp #(
      .SEG_W   (SEG_W),
      .NUM_SEG (NUM_SEG),
      .SEG_IW  (SEG_IW)
   ) u_clamp (
      .sum_i     (raw_sum),
      .cout_i    (seg_cout),
      .sovf_i    (seg_sovf),
      .a_sign_i  (a_sign),
      .lane_ok_i (lane_ok),
      .mask_i    (seg_mask),
      .op_i      (op),
      .res_o     (res_c),
      .ovf_o     (ovf_c)
   );

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_o      <= '0;
            lane_ovf_o <= '0;
         end else begin
            sum_o      <= res_c;
            lane_ovf_o <= ovf_c;
         end
      end
   end else begin : g_comb
      assign sum_o      = res_c;
      assign lane_ovf_o = ovf_c;
   end

endmodule

// File: rtl/simd_sat_adder_chk.sv
// Port-level checker, bound into simd_sat_adder.
module simd_sat_adder_chk #(
   parameter int  DATA_W  = 64,
   parameter int  SEG_W   = 8,
   parameter bit  OUT_REG = 1'b1,
   localparam int NUM_SEG = DATA_W / SEG_W,
   localparam int LOG_SEG = $clog2(NUM_SEG),
   localparam int MODE_W  = $clog2(LOG_SEG + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [DATA_W-1:0]  op_a,
   input logic [DATA_W-1:0]  op_b,
   input logic [MODE_W-1:0]  lane_mode,
   input logic               sub_en,
   input logic               sat_en,
   input logic               signed_en,
   input logic [DATA_W-1:0]  sum_o,
   input logic [NUM_SEG-1:0] lane_ovf_o
);

   localparam logic [MODE_W-1:0] BYTE_MODE = MODE_W'(LOG_SEG);

   // Operands aligned with the outputs they produced.
   logic [DATA_W-1:0] a_d;
   logic [DATA_W-1:0] b_d;
   logic [MODE_W-1:0] m_d;
   logic              sub_d;
   logic              sat_d;
   logic              sgn_d;

   if (OUT_REG) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_d <= '0; b_d <= '0; m_d <= '0;
            sub_d <= 1'b0; sat_d <= 1'b0; sgn_d <= 1'b0;
         end else begin
            a_d <= op_a; b_d <= op_b; m_d <= lane_mode;
            sub_d <= sub_en; sat_d <= sat_en; sgn_d <= signed_en;
         end
      end
   end else begin : g_direct
      assign a_d = op_a;  assign b_d = op_b;  assign m_d = lane_mode;
      assign sub_d = sub_en; assign sat_d = sat_en; assign sgn_d = signed_en;
   end

   logic [SEG_W-1:0] a0, b0, a1, b1, r0, r1;
   logic [SEG_W:0]   add0;
   assign a0   = a_d[SEG_W-1:0];
   assign b0   = b_d[SEG_W-1:0];
   assign a1   = a_d[2*SEG_W-1:SEG_W];
   assign b1   = b_d[2*SEG_W-1:SEG_W];
   assign r0   = sum_o[SEG_W-1:0];
   assign r1   = sum_o[2*SEG_W-1:SEG_W];
   assign add0 = {1'b0, a0} + {1'b0, b0};

   logic [NUM_SEG-1:0] absent;
   always_comb begin
      for (int i = 0; i < NUM_SEG; i++)
         absent[i] = (i >= (1 << ((int'(m_d) > LOG_SEG) ? LOG_SEG : int'(m_d))));
   end

   AST_ABSENT_LANE_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_ovf_o & absent) == '0);                                                    // R7
   AST_LOW_SEG_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      !sat_d |-> r0 == (sub_d ? SEG_W'(a0 - b0) : SEG_W'(a0 + b0)));                 // R3
   AST_FULL_LANE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_d && m_d == '0) |-> sum_o == (sub_d ? a_d - b_d : a_d + b_d));           // R4
   AST_BYTE_LANE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_d && m_d == BYTE_MODE) |-> r1 == (sub_d ? SEG_W'(a1 - b1) : SEG_W'(a1 + b1))); // R2
   AST_UNS_ADD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_d && !sgn_d && !sub_d && m_d == BYTE_MODE && lane_ovf_o[0]) |-> r0 == '1);  // R5
   AST_UNS_SUB_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_d && !sgn_d && sub_d && m_d == BYTE_MODE && lane_ovf_o[0]) |-> r0 == '0);   // R5
   AST_SGN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_d && sgn_d && m_d == BYTE_MODE && lane_ovf_o[0]) |->
         r0 == (a0[SEG_W-1] ? {1'b1, {(SEG_W-1){1'b0}}} : {1'b0, {(SEG_W-1){1'b1}}})); // R6
   AST_UNS_CARRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgn_d && !sub_d && m_d == BYTE_MODE) |-> lane_ovf_o[0] == add0[SEG_W]);       // R7

endmodule

bind simd_sat_adder simd_sat_adder_chk #(
   .DATA_W  (DATA_W),
   .SEG_W   (SEG_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_a       (op_a),
   .op_b       (op_b),
   .lane_mode  (lane_mode),
   .sub_en     (sub_en),
   .sat_en     (sat_en),
   .signed_en  (signed_en),
   .sum_o      (sum_o),
   .lane_ovf_o (lane_ovf_o)
);

// File: tb/simd_sat_adder_bench.sv
`timescale 1ns/1ps
module simd_sat_adder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [1:0]  lane_mode = '0;
   logic        sub_en = 1'b0;
   logic        sat_en = 1'b0;
   logic        signed_en = 1'b0;
   logic [63:0] sum_o;
   logic [7:0]  lane_ovf_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   simd_sat_adder u_simd_sat_adder (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_mode(lane_mode),
      .sub_en(sub_en), .sat_en(sat_en), .signed_en(signed_en),
      .sum_o(sum_o), .lane_ovf_o(lane_ovf_o)
   );

   // Independent lane model written from the requirements.
   function automatic void model(input logic [63:0] a, input logic [63:0] b, input int m,
                                 input bit sub, input bit sat, input bit sgn,
                                 output logic [63:0] r, output logic [7:0] ov);
      int w, n;
      logic [64:0] mask, av, bv, raw, half;
      logic signed [66:0] sa, sb, sr, mx, mn;
      logic [66:0] outv;
      bit o;
      w = 64 >> m;
      n = 1 << m;
      r = '0;
      ov = '0;
      for (int i = 0; i < n; i++) begin
         mask = (65'd1 << w) - 65'd1;
         half = 65'd1 << (w - 1);
         av = ({1'b0, a} >> (i * w)) & mask;
         bv = ({1'b0, b} >> (i * w)) & mask;
         if (!sgn) begin
            raw  = sub ? av - bv : av + bv;
            o    = sub ? (av < bv) : raw[w];
            outv = {2'b00, (sat && o) ? (sub ? 65'd0 : mask) : (raw & mask)};
         end else begin
            sa = $signed({2'b00, av});
            if ((av & half) != 0) sa = sa - $signed({2'b00, mask}) - 67'sd1;
            sb = $signed({2'b00, bv});
            if ((bv & half) != 0) sb = sb - $signed({2'b00, mask}) - 67'sd1;
            sr = sub ? sa - sb : sa + sb;
            mx = $signed({2'b00, half}) - 67'sd1;
            mn = -$signed({2'b00, half});
            o  = (sr > mx) || (sr < mn);
            if (sat && o) sr = (sr > mx) ? mx : mn;
            outv = sr;
         end
         r = r | ((outv[63:0] & mask[63:0]) << (i * w));
         ov[i] = o;
      end
   endfunction

   // Apply one operation, wait through the output register, compare.
   task automatic check_op(input logic [63:0] a, input logic [63:0] b, input int m,
                           input bit sub, input bit sat, input bit sgn, input string req);
      logic [63:0] er;
      logic [7:0]  eo;
      @(negedge clk);
      op_a = a; op_b = b; lane_mode = 2'(m);
      sub_en = sub; sat_en = sat; signed_en = sgn;
      model(a, b, m, sub, sat, sgn, er, eo);
      @(negedge clk);
      n_chk++;
      if (sum_o !== er) begin
         n_bad++;
         $display("FAIL %s result: mode=%0d sub=%0d sat=%0d sgn=%0d got=%h exp=%h",
                  req, m, sub, sat, sgn, sum_o, er);
      end
      n_chk++;
      if (lane_ovf_o !== eo) begin
         n_bad++;
         $display("FAIL %s flags: mode=%0d sub=%0d sat=%0d sgn=%0d got=%b exp=%b",
                  req, m, sub, sat, sgn, lane_ovf_o, eo);
      end
   endtask

   task automatic t_reset();   // R8: reset state
      n_chk++;
      if (sum_o !== 64'd0 || lane_ovf_o !== 8'd0) begin
         n_bad++;
         $display("FAIL R8 reset: got=%h/%b exp=0/0", sum_o, lane_ovf_o);
      end
   endtask

   task automatic t_modes_wrap();   // R1 R2 R3: all-ones plus one wraps every lane
      for (int m = 0; m < 4; m++) check_op('1, 64'h0101_0101_0101_0101, m, 0, 0, 0, "R1 R3");
      check_op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 3, 0, 0, 0, "R2");
      check_op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2, 0, 0, 0, "R2");
   endtask

   task automatic t_subtract();   // R4 R2: borrows stay inside lanes
      check_op(64'h0000_0001_0000_0001, 64'h0000_0002_0000_0002, 1, 1, 0, 0, "R4");
      check_op(64'h1000_0000_0000_0000, 64'h0000_0000_0000_0001, 3, 1, 0, 0, "R4 R2");
      check_op(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0, 1, 0, 0, "R4");
   endtask

   task automatic t_unsigned_sat();   // R5
      check_op(64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_0101_0101, 3, 0, 1, 0, "R5");
      check_op(64'h0003_0003_FFF0_0010, 64'h0004_0001_0020_0020, 2, 1, 1, 0, "R5");
      check_op(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 1, 0, 1, 0, "R5");
   endtask

   task automatic t_signed_sat();   // R6
      check_op(64'h7F80_7F80_7F80_7F80, 64'h0180_0101_01FF_FF01, 3, 0, 1, 1, "R6");
      check_op(64'h8000_7FFF_0000_8000, 64'h0001_FFFF_0001_7FFF, 2, 1, 1, 1, "R6");
      check_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 0, 1, 1, "R6");
   endtask

   task automatic t_flags_no_sat();   // R7: flags visible with wrap
      check_op(64'h7F80_7F80_7F80_7F80, 64'h0180_0101_01FF_FF01, 3, 0, 0, 1, "R7");
      check_op(64'h0000_0001_0000_0002, 64'h0000_0002_0000_0001, 1, 1, 0, 0, "R7");
   endtask

   task automatic t_sweep();   // R8 plus all: pseudo-random over every combination
      logic [63:0] x;
      logic [63:0] y;
      x = 64'h9E37_79B9_7F4A_7C15;
      for (int c = 0; c < 32; c++) begin
         for (int j = 0; j < 10; j++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            y = x ^ (x << 13); y = y ^ (y >> 7); y = y ^ (y << 17);
            check_op(x, y, c & 3, c[2], c[3], c[4], "R8");
         end
      end
   endtask

   initial begin : p_main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_modes_wrap();
      t_subtract();
      t_unsigned_sat();
      t_signed_sat();
      t_flags_no_sat();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : p_watchdog
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog: got=timeout exp=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule